// File: doc/BRIEF.md
# Triggered DAC Sample Sequencer

This block sits in front of a digital-to-analog converter and feeds it one 12-bit sample per trigger. Software loads samples into a 32-entry queue through a small register port. A trigger comes from the rising edge of an external pin or from a software strobe, and each source has its own enable. An accepted trigger removes the oldest sample, presents it on the converter data bus with a one-cycle load strobe, and marks the block busy. The block then counts a programmable number of microsecond ticks for the analog output to settle. When the count ends it drops busy and records a conversion-done event.

A trigger that arrives while a conversion is settling, or while the queue is empty, raises its own sticky error flag. Queue empty, queue full and a programmable depth threshold are live flags that follow the entry count. A write into a full queue is dropped and raises a sticky overflow flag. Software reads a raw flag view and a view masked by an enable register, and clears sticky flags by writing ones. The interrupt line is the OR of the masked view.

Register word addresses on `reg_addr` are: 0 trigger control (bit 0 write-only software strobe, bit 10 pin-trigger enable, bit 11 software-trigger enable), 1 converter control (bits 7:5 settle ticks, bit 8 converter enable), 2 sample write (bits 11:0), 3 queue flush (bit 0), 4 status, 5 depth level (bits 4:0), 6 flag enable, 7 raw flags, 8 masked flags, 9 flag clear. Flag bit order: 0 empty, 1 full, 2 overflow, 3 underflow, 4 done, 5 trigger error, 6 depth threshold.

Top module: `dac_seq_ctrl`

## Requirements
- R1: After reset, status (address 4) reads 0, raw flags read 0x41, depth level reads 16, converter control reads 0, and `irq` and `dac_load` are low.
- R2: Each write to address 2 queues bits 11:0, and status bits 5:0 give the entry count. Samples leave in write order: an accepted trigger drives the oldest sample onto `dac_data` and pulses `dac_load` for one cycle, in the cycle after the trigger.
- R3: A write to address 2 while the count is 32 is dropped, leaves the count at 32, and sets raw bit 2 until it is cleared.
- R4: A trigger counts only while address 1 bit 8 is set. A rising edge of `trig_in` triggers when address 0 bit 10 is set. A write to address 0 with bit 0 set triggers when bit 11 was already set before that write. All other triggers have no effect on the queue, the outputs or the flags.
- R5: Status bit 7 (busy) rises together with the load strobe. It falls, and raw bit 4 is set, on the (S+1)-th `us_tick` cycle after acceptance, where S is address 1 bits 7:5.
- R6: A trigger while busy sets raw bit 5, pops nothing and does not pulse `dac_load`.
- R7: A trigger while not busy with an empty queue sets raw bit 3 and does not pulse `dac_load`.
- R8: Raw bit 0 is (count == 0), raw bit 1 is (count == 32), and raw bit 6 is (count <= depth level). All three follow the count and are not sticky.
- R9: Writing ones to address 9 bits 0..3 clears raw bits 2..5 respectively. Writing address 3 bit 0 empties the queue. Addresses 2, 3 and 9 read as zero.
- R10: Address 8 reads raw flags ANDed with address 6, and `irq` is high exactly when that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| trig_in | input | 1 | External trigger, rising-edge sensitive |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| dac_data | output | 12 | Sample presented to the converter |
| dac_load | output | 1 | One-cycle load strobe for dac_data |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that ends its cycle, so every status, flag and count read is made in the following cycle, and register reads are combinational. The load strobe and the new sample appear in the cycle after the accepted trigger, so the bench samples `dac_load` right after that edge and checks that it has dropped again one cycle later. Busy is checked after each tick, and for every settle setting 0..7 the release must land on exactly the (S+1)-th tick. The queue sweep checks every fill level from 1 to 32 against flag values computed from the count.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
    localparam int REG_AW = 4;
    localparam int REG_DW = 32;
    localparam int FLAG_W = 7;
    localparam int STICKY_W = 4;

    localparam logic [REG_AW-1:0] ADR_TRIG   = 4'd0;
    localparam logic [REG_AW-1:0] ADR_CONV   = 4'd1;
    localparam logic [REG_AW-1:0] ADR_SAMPLE = 4'd2;
    localparam logic [REG_AW-1:0] ADR_FLUSH  = 4'd3;
    localparam logic [REG_AW-1:0] ADR_STAT   = 4'd4;
    localparam logic [REG_AW-1:0] ADR_LEVEL  = 4'd5;
    localparam logic [REG_AW-1:0] ADR_FLGEN  = 4'd6;
    localparam logic [REG_AW-1:0] ADR_RAW    = 4'd7;
    localparam logic [REG_AW-1:0] ADR_MASKED = 4'd8;
    localparam logic [REG_AW-1:0] ADR_CLR    = 4'd9;

    localparam int BIT_SW_GO   = 0;
    localparam int BIT_PIN_EN  = 10;
    localparam int BIT_SW_EN   = 11;
    localparam int BIT_SETTLE  = 5;
    localparam int BIT_CONV_EN = 8;
    localparam int BIT_BUSY    = 7;

    typedef struct packed {
        logic terr;
        logic done;
        logic uflow;
        logic ovf;
    } sticky_t;
endpackage

// File: rtl/dac_seq_fifo.sv
module dac_seq_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 12,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          push_drop
);
    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        empty     = (st_q.count == '0);
        full      = (st_q.count == CW'(DEPTH));
        do_push   = push && !full;
        do_pop    = pop && !empty;
        push_drop = push && full;
        st_d      = st_q;
        if (do_push) st_d.wr_ptr = ptr_next(st_q.wr_ptr);
        if (do_pop)  st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        st_d.count = st_q.count + CW'(do_push) - CW'(do_pop);
        if (flush) st_d = '0;
        head  = mem_q[st_q.rd_ptr];
        count = st_q.count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= push_data;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/dac_seq_engine.sv
module dac_seq_engine #(
    parameter int DW = 12,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_head,
    input  logic          us_tick,
    input  logic [SW-1:0] settle,
    output logic          pop,
    output logic [DW-1:0] out_data,
    output logic          out_load,
    output logic          busy,
    output logic          done_set,
    output logic          uflow_set,
    output logic          terr_set
);
    typedef struct packed {
        logic          busy;
        logic [SW-1:0] ticks;
        logic [DW-1:0] data;
        logic          load;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        accept    = trig && !st_q.busy && !fifo_empty;
        terr_set  = trig && st_q.busy;
        uflow_set = trig && !st_q.busy && fifo_empty;
        pop       = accept;
        done_set  = 1'b0;
        st_d      = st_q;
        st_d.load = 1'b0;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.ticks = '0;
            st_d.data  = fifo_head;
            st_d.load  = 1'b1;
        end else if (st_q.busy && us_tick) begin
            if (st_q.ticks >= settle) begin
                st_d.busy = 1'b0;
                done_set  = 1'b1;
            end else begin
                st_d.ticks = st_q.ticks + SW'(1);
            end
        end
        out_data = st_q.data;
        out_load = st_q.load;
        busy     = st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_load |-> busy);
    assert_release_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(us_tick));
    assert_err_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        terr_set |-> !pop);
    assert_uflow_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow_set && !accept) |=> !out_load);
endmodule

// File: rtl/dac_seq_flags.sv
module dac_seq_flags
    import dac_seq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = 5,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       count,
    input  logic [LW-1:0]       level,
    input  sticky_t             set,
    input  sticky_t             clr,
    input  logic [FLAG_W-1:0]   enable,
    output logic [FLAG_W-1:0]   raw,
    output logic [FLAG_W-1:0]   masked,
    output logic                irq
);
    sticky_t sticky_d, sticky_q;
    logic    lvl_hit;

    always_comb begin
        sticky_d = (sticky_q & ~clr) | set;
        if (CW > LW) lvl_hit = (count <= CW'(level));
        else         lvl_hit = (LW'(count) <= level);
        raw    = {lvl_hit, sticky_q, (count == CW'(DEPTH)), (count == '0)};
        masked = raw & enable;
        irq    = |masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    assert_clear_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr.ovf && !set.ovf) |=> !raw[2]);
    assert_sticky_terr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q.terr && !clr.terr) |=> sticky_q.terr);
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int SAMPLE_W  = 12,
    parameter int SETTLE_W  = 3,
    parameter int LEVEL_W   = 5,
    parameter int LEVEL_RST = 16,
    localparam int CW       = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic                trig_in,
    input  logic                us_tick,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic                dac_load,
    output logic                irq
);
    typedef struct packed {
        logic                pin_en;
        logic                sw_en;
        logic                conv_en;
        logic [SETTLE_W-1:0] settle;
        logic [LEVEL_W-1:0]  level;
        logic [FLAG_W-1:0]   flag_en;
        logic                pin_prev;
    } cfg_t;

    cfg_t               cfg_d, cfg_q;
    logic               wr_trig, wr_conv, wr_sample, wr_flush, wr_level, wr_flgen, wr_clr;
    logic               trig_req;
    logic [SAMPLE_W-1:0] head;
    logic [CW-1:0]      count;
    logic               empty, full, push_drop, pop, busy;
    logic               done_set, uflow_set, terr_set;
    sticky_t            set_v, clr_v;
    logic [FLAG_W-1:0]  raw, masked;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        wr_trig   = reg_wr && (reg_addr == ADR_TRIG);
        wr_conv   = reg_wr && (reg_addr == ADR_CONV);
        wr_sample = reg_wr && (reg_addr == ADR_SAMPLE);
        wr_flush  = reg_wr && (reg_addr == ADR_FLUSH) && reg_wdata[0];
        wr_level  = reg_wr && (reg_addr == ADR_LEVEL);
        wr_flgen  = reg_wr && (reg_addr == ADR_FLGEN);
        wr_clr    = reg_wr && (reg_addr == ADR_CLR);

        trig_req = cfg_q.conv_en &&
                   ((trig_in && !cfg_q.pin_prev && cfg_q.pin_en) ||
                    (wr_trig && reg_wdata[BIT_SW_GO] && cfg_q.sw_en));

        cfg_d          = cfg_q;
        cfg_d.pin_prev = trig_in;
        if (wr_trig) begin
            cfg_d.pin_en = reg_wdata[BIT_PIN_EN];
            cfg_d.sw_en  = reg_wdata[BIT_SW_EN];
        end
        if (wr_conv) begin
            cfg_d.conv_en = reg_wdata[BIT_CONV_EN];
            cfg_d.settle  = reg_wdata[BIT_SETTLE +: SETTLE_W];
        end
        if (wr_level) cfg_d.level   = reg_wdata[LEVEL_W-1:0];
        if (wr_flgen) cfg_d.flag_en = reg_wdata[FLAG_W-1:0];

        clr_v = wr_clr ? sticky_t'(reg_wdata[STICKY_W-1:0]) : '0;
        set_v = '{terr: terr_set, done: done_set, uflow: uflow_set, ovf: push_drop};

        reg_rdata = '0;
        case (reg_addr)
            ADR_TRIG: begin
                reg_rdata[BIT_PIN_EN] = cfg_q.pin_en;
                reg_rdata[BIT_SW_EN]  = cfg_q.sw_en;
            end
            ADR_CONV: begin
                reg_rdata[BIT_SETTLE +: SETTLE_W] = cfg_q.settle;
                reg_rdata[BIT_CONV_EN]            = cfg_q.conv_en;
            end
            ADR_STAT: begin
                reg_rdata[CW-1:0]   = count;
                reg_rdata[BIT_BUSY] = busy;
            end
            ADR_LEVEL:  reg_rdata[LEVEL_W-1:0] = cfg_q.level;
            ADR_FLGEN:  reg_rdata[FLAG_W-1:0]  = cfg_q.flag_en;
            ADR_RAW:    reg_rdata[FLAG_W-1:0]  = raw;
            ADR_MASKED: reg_rdata[FLAG_W-1:0]  = masked;
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.level <= LEVEL_W'(LEVEL_RST);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    dac_seq_fifo #(.DEPTH(DEPTH), .DW(SAMPLE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_sample),
        .push_data (reg_wdata[SAMPLE_W-1:0]),
        .pop       (pop),
        .flush     (wr_flush),
        .head      (head),
        .count     (count),
        .empty     (empty),
        .full      (full),
        .push_drop (push_drop)
    );

    dac_seq_engine #(.DW(SAMPLE_W), .SW(SETTLE_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig_req),
        .fifo_empty (empty),
        .fifo_head  (head),
        .us_tick    (us_tick),
        .settle     (cfg_q.settle),
        .pop        (pop),
        .out_data   (dac_data),
        .out_load   (dac_load),
        .busy       (busy),
        .done_set   (done_set),
        .uflow_set  (uflow_set),
        .terr_set   (terr_set)
    );

    dac_seq_flags #(.DEPTH(DEPTH), .LW(LEVEL_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (count),
        .level  (cfg_q.level),
        .set    (set_v),
        .clr    (clr_v),
        .enable (cfg_q.flag_en),
        .raw    (raw),
        .masked (masked),
        .irq    (irq)
    );

    assert_gated_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.conv_en |=> !dac_load);
    assert_full_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raw[1] |-> !raw[0]);
endmodule

// File: tb/dac_seq_ctrl_bench.sv
`timescale 1ns/1ps
module dac_seq_ctrl_bench;
    logic        clk = 0, rst_n = 0, reg_wr = 0, trig_in = 0, us_tick = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, rv;
    logic [11:0] dac_data;
    logic        dac_load, irq;
    int          n_chk = 0, n_err = 0;
    bit          done_flag = 0;

    always #2.5 clk = ~clk;

    dac_seq_ctrl u_dac_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .us_tick(us_tick), .dac_data(dac_data), .dac_load(dac_load), .irq(irq)
    );

    localparam logic [31:0] SW_EN = 32'h800, PIN_EN = 32'h400, GO = 32'h1, CONV = 32'h100;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk); us_tick = 1;
        @(negedge clk); us_tick = 0;
    endtask

    task automatic pin_pulse();
        @(negedge clk); trig_in = 1;
        @(negedge clk); trig_in = 0;
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic logic [11:0] sval(input int n);
        return 12'((n * 37 + 5) % 4096);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4, rv); chk("R1 status", rv, 0);
        rd(7, rv); chk("R1 raw", rv, 32'h41);
        rd(5, rv); chk("R1 level", rv, 16);
        rd(1, rv); chk("R1 conv ctrl", rv, 0);
        chk("R1 irq", irq, 0);
        chk("R1 load", dac_load, 0);

        wr(5, 10);
        wr(1, CONV);
        wr(0, SW_EN | PIN_EN);

        // R2/R8 fill sweep
        for (int n = 1; n <= 32; n++) begin
            wr(2, {20'hFFFFF, sval(n)});
            rd(4, rv); chk("R2 count", rv, n);
            rd(7, rv); chk("R8 level flags", rv, ((n == 32) ? 32'h2 : 0) | ((n <= 10) ? 32'h40 : 0));
        end
        // R3 overflow
        wr(2, 12'hABC);
        rd(4, rv); chk("R3 count held", rv, 32);
        rd(7, rv); chk("R3 overflow flag", rv, 32'h06);
        // R9 clear
        wr(9, 1);
        rd(7, rv); chk("R9 overflow cleared", rv, 32'h02);
        rd(9, rv); chk("R9 clear reads zero", rv, 0);
        rd(2, rv); chk("R9 sample reads zero", rv, 0);

        // R2/R5 drain in order
        for (int k = 1; k <= 32; k++) begin
            wr(0, SW_EN | PIN_EN | GO);
            chk("R2 load pulse", dac_load, 1);
            chk("R2 order", dac_data, sval(k));
            rd(4, rv); chk("R5 busy set", rv, (32 - k) | 32'h80);
            tick();
            chk("R2 load single", dac_load, 0);
            rd(4, rv); chk("R5 busy clear", rv, 32 - k);
        end
        rd(7, rv); chk("R8 R5 raw after drain", rv, 32'h51);
        wr(9, 4);
        rd(7, rv); chk("R9 done cleared", rv, 32'h41);

        // R7 underflow
        wr(0, SW_EN | PIN_EN | GO);
        chk("R7 no load", dac_load, 0);
        rd(7, rv); chk("R7 underflow flag", rv, 32'h49);
        wr(9, 2);

        // R5 settle sweep
        for (int s = 0; s < 8; s++) begin
            wr(1, CONV | (s << 5));
            wr(2, s);
            wr(0, SW_EN | PIN_EN | GO);
            chk("R5 load", dac_load, 1);
            for (int i = 0; i <= s; i++) begin
                tick();
                rd(4, rv); chk("R5 busy per tick", rv, (i < s) ? 32'h80 : 0);
            end
            rd(7, rv); chk("R5 done flag", rv & 32'h10, 32'h10);
            wr(9, 4);
        end

        // R6 trigger while busy
        wr(2, 12'h111);
        wr(2, 12'h222);
        wr(0, SW_EN | PIN_EN | GO);
        chk("R6 first load", dac_data, 12'h111);
        wr(0, SW_EN | PIN_EN | GO);
        chk("R6 no second load", dac_load, 0);
        rd(4, rv); chk("R6 count kept", rv, 1 | 32'h80);
        rd(7, rv); chk("R6 error flag", rv, 32'h60);
        repeat (8) tick();
        wr(9, 8 | 4);

        // R4 source enables
        wr(0, SW_EN);
        pin_pulse();
        chk("R4 pin disabled load", dac_load, 0);
        rd(4, rv); chk("R4 pin disabled count", rv, 1);
        wr(0, PIN_EN);
        pin_pulse();
        chk("R4 pin load", dac_load, 1);
        chk("R4 pin data", dac_data, 12'h222);
        repeat (8) tick();
        wr(9, 4);
        wr(2, 12'h333);
        wr(0, PIN_EN | GO);
        chk("R4 sw disabled load", dac_load, 0);
        rd(4, rv); chk("R4 sw disabled count", rv, 1);
        wr(1, 0);
        pin_pulse();
        chk("R4 conv off load", dac_load, 0);
        rd(4, rv); chk("R4 conv off count", rv, 1);
        rd(7, rv); chk("R4 conv off flags", rv, 32'h40);
        // R9 flush
        wr(3, 1);
        rd(4, rv); chk("R9 flush count", rv, 0);
        rd(3, rv); chk("R9 flush reads zero", rv, 0);

        // R10 masking
        wr(6, 32'h08);
        chk("R10 irq masked off", irq, 0);
        wr(1, CONV);
        wr(0, SW_EN);
        wr(0, SW_EN | GO);
        rd(8, rv); chk("R10 masked view", rv, 32'h08);
        chk("R10 irq on", irq, 1);
        wr(6, 32'h7F);
        rd(8, rv); chk("R10 full mask", rv, 32'h49);
        wr(9, 2);
        rd(8, rv); chk("R10 after clear", rv, 32'h41);
        chk("R10 irq level flags", irq, 1);
        wr(6, 0);
        chk("R10 irq off", irq, 0);

        done_flag = 1;
        finish_up();
    end
endmodule